// File: doc/BRIEF.md
# Page Buffer and Self-Timed Write Controller

This block sits behind the serial protocol engine of a small two-wire EEPROM. During a write transaction the engine hands it the starting word address, then each received data byte with a one-cycle strobe, and finally a STOP event. The block keeps the bytes in a page-sized buffer whose byte pointer wraps inside the addressed page. A per-slot loaded mask records which locations were filled. After a STOP that ends a transaction with at least one loaded byte, it runs a self-timed write cycle of `WRITE_CYCLES` clock cycles. During that cycle it issues one array write per loaded location and holds `busy` high.

The protocol engine watches `busy`. While it is high, the engine ignores commands and does not acknowledge a polled device address. The block itself also ignores every strobe while `busy` is high. If the write-protect input is high when the STOP arrives, the buffered bytes are discarded: no array write takes place and `busy` stays low. A STOP that ends a transaction in which no byte was loaded, such as the address-only write in front of a random read, starts no write cycle. The page size is set by `PAGE_BYTES`, which is 8 for the two smallest densities and 16 for the larger ones. `WRITE_CYCLES` must be at least `PAGE_BYTES`.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset `busy` is low and `memWe` is low.
- R2: `addrLoad` takes the page row from `wordAddr[ADDR_W-1:log2(PAGE_BYTES)]` and the byte pointer from the low `log2(PAGE_BYTES)` bits. Each accepted `byteValid` stores `byteData` at the pointer, and the pointer then advances by one. Every commit write goes to an address inside that row.
- R3: After the last slot of the page, the pointer wraps to slot 0 of the same row. A byte stored at a slot that was already loaded replaces the earlier byte, so the array receives the last byte stored there.
- R4: Only loaded slots are written to the array. There is exactly one write per loaded slot (at most `PAGE_BYTES` writes), and every other array location keeps its contents.
- R5: A STOP with write-protect low and at least one byte loaded raises `busy` on the next cycle. `busy` then stays high for exactly `WRITE_CYCLES` cycles, and all commit writes happen while it is high.
- R6: While `busy` is high, `addrLoad`, `byteValid` and `stopEvent` have no effect. They load no address and no byte, and they start no further write cycle. When `busy` falls, the block accepts a new transaction.
- R7: A STOP with write-protect high writes nothing to the array and never raises `busy`. It also discards the loaded bytes.
- R8: A STOP with no byte loaded since the last `addrLoad` (or since the last completed or discarded transaction) starts no write cycle. `busy` stays low and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordAddr | input | ADDR_W | Starting word address of the transaction |
| addrLoad | input | 1 | Strobe: load `wordAddr` and clear the loaded mask |
| byteData | input | DATA_W | Received data byte |
| byteValid | input | 1 | Strobe: store `byteData` at the byte pointer |
| stopEvent | input | 1 | Strobe: STOP seen on the bus |
| wpIn | input | 1 | Write-protect level, sampled with `stopEvent` |
| busy | output | 1 | Write cycle in progress |
| memWe | output | 1 | Array write enable for one byte |
| memAddr | output | ADDR_W | Array write address |
| memData | output | DATA_W | Array write data |

## Verification
The main sweep covers every starting offset within a page combined with every byte count from one to one and a half pages. It also moves each transaction to a different row. Counts below the page size separate partial commits from full ones, and counts above it show whether the pointer wraps inside the row or spills into the next row. The array image is checked after every commit, along with the write count and the length of `busy`. Separate sequences apply write-protect at the STOP, a STOP with nothing loaded, and a full set of strobes issued during `busy`. Each of these is followed by a bare STOP, which shows whether any stale byte was left in the buffer.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  // Strobes from the control FSM to the page datapath
  typedef struct packed {
    logic loadAddr;   // take row and pointer, clear loaded mask
    logic storeByte;  // write data at pointer, advance pointer
    logic clearMask;  // drop all loaded flags
    logic scanOn;     // commit scan active this cycle
  } pgStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_COMMIT = 1'b1
  } pgState_e;

endpackage

// File: rtl/pgbuf_datapath.sv
module pgbuf_datapath
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgStrobe_t         ctrl,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] byteData,
  input  logic [$clog2(PAGE_BYTES)-1:0] scanIdx,
  output logic              maskAny,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pageRow,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int ROW_W = ADDR_W - OFS_W;

  logic [ROW_W-1:0]      rowQ;
  logic [OFS_W-1:0]      ptrQ;
  logic [PAGE_BYTES-1:0] loadedQ;
  logic [DATA_W-1:0]     slotQ [PAGE_BYTES];

  // Row is frozen for the whole transaction; pointer wraps inside page
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ <= '0;
      ptrQ <= '0;
    end else if (ctrl.loadAddr) begin
      rowQ <= wordAddr[ADDR_W-1:OFS_W];
      ptrQ <= wordAddr[OFS_W-1:0];
    end else if (ctrl.storeByte) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  // Per-slot data and loaded flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadedQ <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) slotQ[i] <= '0;
    end else begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (ctrl.loadAddr || ctrl.clearMask) begin
          loadedQ[i] <= 1'b0;
        end else if (ctrl.storeByte && (ptrQ == OFS_W'(i))) begin
          loadedQ[i] <= 1'b1;
          slotQ[i]   <= byteData;
        end
      end
    end
  end

  assign maskAny = |loadedQ;
  assign pageRow = rowQ;

  // Commit port: one slot per scan cycle, skipped if never loaded
  assign memWe   = ctrl.scanOn & loadedQ[scanIdx];
  assign memAddr = {rowQ, scanIdx};
  assign memData = slotQ[scanIdx];

endmodule

// File: rtl/pgbuf_control.sv
module pgbuf_control
  import pgwr_pkg::*;
#(
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      addrLoad,
  input  logic      byteValid,
  input  logic      stopEvent,
  input  logic      wpIn,
  input  logic      maskAny,
  output pgStrobe_t ctrl,
  output logic [$clog2(PAGE_BYTES)-1:0] scanIdx,
  output logic      busy
);

  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);

  pgState_e        stateQ;
  logic [CNT_W-1:0] cycleCntQ;
  logic            accept;
  logic            goBusy;
  logic            lastCycle;

  assign accept    = (stateQ == ST_IDLE);
  assign goBusy    = accept && stopEvent && !wpIn && maskAny;
  assign lastCycle = (stateQ == ST_COMMIT) && (cycleCntQ == LAST_CNT);

  always_comb begin
    ctrl           = '0;
    ctrl.loadAddr  = accept && addrLoad;
    ctrl.storeByte = accept && byteValid && !addrLoad && !stopEvent;
    // A STOP that starts no cycle (empty or protected) drops the buffer;
    // a finished cycle also leaves the buffer empty.
    ctrl.clearMask = (accept && stopEvent && !goBusy) || lastCycle;
    ctrl.scanOn    = (stateQ == ST_COMMIT) && (cycleCntQ < SCAN_END);
  end

  assign scanIdx = cycleCntQ[OFS_W-1:0];
  assign busy    = (stateQ == ST_COMMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      cycleCntQ <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (goBusy) begin
            stateQ    <= ST_COMMIT;
            cycleCntQ <= '0;
          end
        end
        ST_COMMIT: begin
          if (lastCycle) begin
            stateQ    <= ST_IDLE;
            cycleCntQ <= '0;
          end else begin
            cycleCntQ <= cycleCntQ + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              addrLoad,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteValid,
  input  logic              stopEvent,
  input  logic              wpIn,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int ROW_W = ADDR_W - OFS_W;

  pgStrobe_t        ctrl;
  logic [OFS_W-1:0] scanIdx;
  logic             maskAny;
  logic [ROW_W-1:0] pageRow;

  pgbuf_control #(
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addrLoad (addrLoad),
    .byteValid(byteValid),
    .stopEvent(stopEvent),
    .wpIn     (wpIn),
    .maskAny  (maskAny),
    .ctrl     (ctrl),
    .scanIdx  (scanIdx),
    .busy     (busy)
  );

  pgbuf_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .wordAddr(wordAddr),
    .byteData(byteData),
    .scanIdx (scanIdx),
    .maskAny (maskAny),
    .pageRow (pageRow),
    .memWe   (memWe),
    .memAddr (memAddr),
    .memData (memData)
  );

endmodule

// File: rtl/pgwr_checker.sv
module pgwr_checker #(
  parameter int ROW_W        = 7,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             memWe,
  input logic             stopEvent,
  input logic             wpIn,
  input logic             maskAny,
  input logic [ROW_W-1:0] pageRow
);

  localparam int RUN_W = $clog2(WRITE_CYCLES + 2) + 1;
  localparam int WE_W  = $clog2(PAGE_BYTES + 2) + 1;

  logic [RUN_W-1:0] runCnt;
  logic [WE_W-1:0]  weCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      weCnt  <= '0;
    end else begin
      runCnt <= busy ? runCnt + 1'b1 : '0;
      weCnt  <= busy ? weCnt + WE_W'(memWe) : '0;
    end
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R5
  AST_START_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopEvent && !wpIn && maskAny) |=> busy); // R5
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runCnt < RUN_W'(WRITE_CYCLES))); // R5
  AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runCnt == RUN_W'(WRITE_CYCLES))); // R5
  AST_WP_NO_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopEvent && wpIn) |=> !busy); // R7
  AST_EMPTY_NO_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopEvent && !maskAny) |=> !busy); // R8
  AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(pageRow)); // R6
  AST_WE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (weCnt <= WE_W'(PAGE_BYTES))); // R4

endmodule

bind page_write_ctrl pgwr_checker #(
  .ROW_W       (ADDR_W - $clog2(PAGE_BYTES)),
  .PAGE_BYTES  (PAGE_BYTES),
  .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .memWe    (memWe),
  .stopEvent(stopEvent),
  .wpIn     (wpIn),
  .maskAny  (maskAny),
  .pageRow  (pageRow)
);

// File: tb/tb_page_write_ctrl.sv
module tb_page_write_ctrl;

  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int PB     = 8;
  localparam int WC     = 20;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] wordAddr = '0;
  logic              addrLoad = 1'b0;
  logic [DATA_W-1:0] byteData = '0;
  logic              byteValid = 1'b0;
  logic              stopEvent = 1'b0;
  logic              wpIn = 1'b0;
  logic              busy, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;

  int checks = 0;
  int errors = 0;
  int writes = 0;
  int badRow = 0;
  int expRow = 0;
  logic [DATA_W-1:0] gotMem [DEPTH];
  logic [DATA_W-1:0] expMem [DEPTH];

  always #4 clk = ~clk;

  page_write_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)
  ) dut (
    .clk(clk), .rstN(rstN), .wordAddr(wordAddr), .addrLoad(addrLoad),
    .byteData(byteData), .byteValid(byteValid), .stopEvent(stopEvent),
    .wpIn(wpIn), .busy(busy), .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  // Array model driven only by the commit port
  always @(negedge clk) begin
    if (rstN && memWe) begin
      gotMem[memAddr] = memData;
      writes++;
      if (int'(memAddr) / PB != expRow) badRow++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic load_addr(input int a);
    @(negedge clk); wordAddr = ADDR_W'(a); addrLoad = 1'b1;
    @(negedge clk); addrLoad = 1'b0;
  endtask

  task automatic send_byte(input logic [DATA_W-1:0] d);
    @(negedge clk); byteData = d; byteValid = 1'b1;
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic send_stop(input logic wp);
    @(negedge clk); stopEvent = 1'b1; wpIn = wp;
    @(negedge clk); stopEvent = 1'b0; wpIn = 1'b0;
  endtask

  // Called right after send_stop: counts busy cycles until it falls
  task automatic busy_len(output int len);
    len = 0;
    while (busy && len < 10 * WC) begin
      len++;
      @(negedge clk);
    end
  endtask

  // Watch busy for n cycles; returns number of cycles it was high
  task automatic busy_seen(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (busy) hi++;
      @(negedge clk);
    end
  endtask

  function automatic int mem_diffs();
    int d = 0;
    for (int i = 0; i < DEPTH; i++) if (gotMem[i] !== expMem[i]) d++;
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] pat(input int t, input int j);
    return DATA_W'(t * 29 + j * 13 + 7);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int len, hi, t, row, nexp;
    for (int i = 0; i < DEPTH; i++) begin gotMem[i] = '0; expMem[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
    check(memWe === 1'b0, "R1 memWe in reset", int'(memWe), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && writes == 0, "R1 idle after reset", writes, 0);

    // R2 R3 R4 R5: every offset x byte count 1..1.5 pages, rotating rows
    t = 0;
    for (int off = 0; off < PB; off++) begin
      for (int n = 1; n <= PB + PB / 2; n++) begin
        row = t % (DEPTH / PB);
        expRow = row;
        writes = 0;
        badRow = 0;
        load_addr(row * PB + off);
        for (int j = 0; j < n; j++) begin
          send_byte(pat(t, j));
          expMem[row * PB + (off + j) % PB] = pat(t, j);
        end
        send_stop(1'b0);
        busy_len(len);
        check(len == WC, "R5 busy length", len, WC);
        nexp = (n < PB) ? n : PB;
        check(writes == nexp, "R4 one write per loaded slot", writes, nexp);
        check(badRow == 0, "R2 writes stay in row", badRow, 0);
        check(mem_diffs() == 0, "R3 array image after wrap/partial", mem_diffs(), 0);
        t++;
      end
    end

    // R7: write protect at STOP
    expRow = 3;
    writes = 0;
    load_addr(3 * PB + 1);
    send_byte(8'hA5); send_byte(8'h5A);
    send_stop(1'b1);
    busy_seen(WC + 4, hi);
    check(hi == 0, "R7 busy under write protect", hi, 0);
    check(writes == 0, "R7 no write under write protect", writes, 0);
    check(mem_diffs() == 0, "R7 array unchanged", mem_diffs(), 0);
    send_stop(1'b0);  // buffer must have been discarded
    busy_seen(WC + 4, hi);
    check(hi == 0 && writes == 0, "R7 protected bytes discarded", hi + writes, 0);

    // R8: STOP with nothing loaded (address-only transaction)
    load_addr(5 * PB + 2);
    send_stop(1'b0);
    busy_seen(WC + 4, hi);
    check(hi == 0, "R8 no cycle for empty STOP", hi, 0);
    check(writes == 0, "R8 no write for empty STOP", writes, 0);

    // R6: strobes during busy are ignored
    expRow = 6;
    writes = 0;
    load_addr(6 * PB + 2);
    for (int j = 0; j < 3; j++) begin
      send_byte(pat(900, j));
      expMem[6 * PB + 2 + j] = pat(900, j);
    end
    send_stop(1'b0);
    check(busy === 1'b1, "R5 busy after STOP", int'(busy), 1);
    load_addr(9 * PB);
    send_byte(8'hEE); send_byte(8'hDD);
    send_stop(1'b0);
    while (busy) @(negedge clk);
    check(writes == 3, "R6 only first transaction written", writes, 3);
    check(badRow == 0, "R6 row not moved during busy", badRow, 0);
    check(mem_diffs() == 0, "R6 array after ignored strobes", mem_diffs(), 0);
    busy_seen(4, hi);
    check(hi == 0, "R6 ignored STOP started no cycle", hi, 0);
    send_stop(1'b0);
    busy_seen(WC + 4, hi);
    check(hi == 0, "R6 ignored bytes not buffered", hi, 0);

    // R6: standby again, new transaction accepted
    expRow = 2;
    writes = 0;
    load_addr(2 * PB + 7);
    send_byte(8'h3C);
    expMem[2 * PB + 7] = 8'h3C;
    send_stop(1'b0);
    busy_len(len);
    check(len == WC, "R6 cycle after standby", len, WC);
    check(mem_diffs() == 0 && writes == 1, "R6 single byte after standby", writes, 1);

    finish_run();
  end

endmodule